// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Controller

This block sits in the feedback path of a synthesizer loop, behind an external two-ratio prescaler. Each edge of the prescaler output arrives on `fin` and is counted. The block divides that edge stream with two coupled down-counters: a main count and an auxiliary "swallow" count. It also drives `mod_ctrl`, which tells the prescaler which of its two ratios to use.

While swallow counts remain, `mod_ctrl` stays low, so the prescaler divides by P+1. Once the swallow count is used up, `mod_ctrl` goes high, so the prescaler divides by P, and the main count carries on alone. When the main count expires:

- both counts reload, and
- a one-clock `fv` pulse goes to the phase comparator.

Over one full cycle the overall division from prescaler input to `fv` is N*P+A.

New ratio values are written with a one-cycle `prog_load` strobe. They are held in a pending register and take effect only at the next reload, so a division cycle is never cut short or stretched by a write. The `fin` input is asynchronous to `clk`. It passes through a synchronizer of configurable depth before its edges are detected.

Top module: `dmd_feedback_divider`

## Requirements
- R1: After reset, `fv` is low and the active ratio is DEF_N/DEF_A (defaults 10 and 0). With DEF_A=0, `mod_ctrl` is high and the first full cycle spans DEF_N*P prescaler input periods.
- R2: Exactly one count is taken per rising `fin` edge, however long `fin` stays high. With SYNC_STAGES=2, an output caused by an edge changes on the third `clk` rising edge after `fin` is first sampled high.
- R3: `mod_ctrl` is low (ratio P+1) for the first A counted edges of each cycle, when 1 <= A <= N.
- R4: After the swallow count reaches zero, `mod_ctrl` is high (ratio P) for the remaining N-A edges. When A=0, it is high for the whole cycle.
- R5: With an ideal prescaler that divides by P+1 when `mod_ctrl`=0 and by P when `mod_ctrl`=1, each `fv` period spans N*P+A prescaler input periods.
- R6: `fv` is a single-clock pulse. It occurs once every N counted edges.
- R7: With N=1, `fv` pulses on every counted edge.
- R8: Values written by `prog_load` leave the cycle in progress unchanged. They apply from the next reload onward.
- R9: A write with `prog_n`=0 is discarded entirely. Both pending values keep their previous contents.
- R10: If A > N, the cycle still ends after N edges, with `mod_ctrl` low on every one, giving N*(P+1).
- R11: The extreme settings N=1023 and A=127 divide by 1023*P+127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fin | input | 1 | Prescaler output, counted on its rising edge |
| prog_n | input | 10 | Main ratio N to be written (1..1023) |
| prog_a | input | 7 | Swallow count A to be written (0..127) |
| prog_load | input | 1 | One-cycle strobe that captures `prog_n`/`prog_a` as pending |
| mod_ctrl | output | 1 | Prescaler ratio select: 0 = P+1, 1 = P |
| fv | output | 1 | One-clock pulse at each main-count expiry |

## Verification
A `fin` edge becomes a count after two synchronizer stages and one edge register. The bench therefore raises `fin` just after a falling `clk` edge and looks for `fv` exactly three falling edges later, and at no earlier sample.

`mod_ctrl` has settled by the time the next `fin` edge is issued. The bench's prescaler model reads it then to decide whether that edge cost P or P+1 input periods. Cycle totals are summed between consecutive `fv` pulses, after first aligning to a reload, so pending values are known to be active. Deferred writes are checked by measuring the cycle already in progress and the one after it.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

   // Prescaler ratio selected by the modulus-control output.
   typedef enum logic {
      RATIO_P_PLUS_1 = 1'b0,
      RATIO_P        = 1'b1
   } ratio_sel_e;

   // Default widths for the two counters.
   localparam int unsigned DMD_N_W = 10;
   localparam int unsigned DMD_A_W = 7;

   // Largest value a counter of the given width can hold.
   function automatic int unsigned dmd_max_val(input int unsigned w);
      return (1 << w) - 1;
   endfunction

endpackage

// File: rtl/dmd_fin_edge.sv
module dmd_fin_edge #(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          COUNT_FALLING = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fin,
   output logic hit
);

   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("dmd_fin_edge: SYNC_STAGES must be 0..4");
   end

   logic [SYNC_STAGES:0] chain;
   logic                 lvl;
   logic                 prev_q;

   assign chain[0] = fin;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i+1] <= 1'b0;
         else        chain[i+1] <= chain[i];
      end
   end

   assign lvl = chain[SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   if (COUNT_FALLING) begin : g_fall
      assign hit = ~lvl & prev_q;
   end else begin : g_rise
      assign hit = lvl & ~prev_q;
   end

   // One count per edge: a detected edge can never last two clocks.
   p_edge_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);

endmodule

// File: rtl/dmd_ratio_shadow.sv
module dmd_ratio_shadow #(
   parameter int unsigned N_W   = 10,
   parameter int unsigned A_W   = 7,
   parameter int unsigned DEF_N = 10,
   parameter int unsigned DEF_A = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           prog_load,
   input  logic [N_W-1:0] prog_n,
   input  logic [A_W-1:0] prog_a,
   output logic [N_W-1:0] pend_n,
   output logic [A_W-1:0] pend_a
);

   logic accept;

   // A write carrying a zero main ratio is dropped as a whole.
   assign accept = prog_load && (prog_n != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_n <= N_W'(DEF_N);
         pend_a <= A_W'(DEF_A);
      end else if (accept) begin
         pend_n <= prog_n;
         pend_a <= prog_a;
      end
   end

   p_zero_n_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_load && prog_n == '0) |=> ($stable(pend_n) && $stable(pend_a)));

   p_pending_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_n != '0);

endmodule

// File: rtl/dmd_count_core.sv
module dmd_count_core
   import dmd_pkg::*;
#(
   parameter int unsigned N_W   = 10,
   parameter int unsigned A_W   = 7,
   parameter int unsigned DEF_N = 10,
   parameter int unsigned DEF_A = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ev,
   input  logic [N_W-1:0] pend_n,
   input  logic [A_W-1:0] pend_a,
   output logic           mod_ctrl,
   output logic           fv
);

   localparam logic [N_W-1:0] N_ONE = N_W'(1);

   logic [N_W-1:0] n_cnt;
   logic [A_W-1:0] a_cnt;
   logic [A_W-1:0] a_dec;
   logic           terminal;
   ratio_sel_e     sel_q;
   logic           fv_q;

   assign terminal = ev && (n_cnt <= N_ONE);
   assign a_dec    = (a_cnt != '0) ? a_cnt - A_W'(1) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_cnt <= N_W'(DEF_N);
         a_cnt <= A_W'(DEF_A);
         sel_q <= (DEF_A == 0) ? RATIO_P : RATIO_P_PLUS_1;
         fv_q  <= 1'b0;
      end else begin
         fv_q <= terminal;
         if (terminal) begin
            n_cnt <= pend_n;
            a_cnt <= pend_a;
            sel_q <= (pend_a == '0) ? RATIO_P : RATIO_P_PLUS_1;
         end else if (ev) begin
            n_cnt <= n_cnt - N_ONE;
            a_cnt <= a_dec;
            sel_q <= (a_dec == '0) ? RATIO_P : RATIO_P_PLUS_1;
         end
      end
   end

   assign mod_ctrl = (sel_q == RATIO_P);
   assign fv       = fv_q;

   p_hold_without_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ev |=> ($stable(n_cnt) && $stable(a_cnt)));

   p_fv_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fv |=> !fv);

   p_mc_low_while_swallow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && n_cnt > N_ONE && a_cnt > A_W'(1)) |=> !mod_ctrl);

   p_mc_high_after_swallow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && n_cnt > N_ONE && a_cnt <= A_W'(1)) |=> mod_ctrl);

   p_reload_takes_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      terminal |=> (n_cnt == $past(pend_n) && a_cnt == $past(pend_a)));

endmodule

// File: rtl/dmd_feedback_divider.sv
module dmd_feedback_divider
   import dmd_pkg::*;
#(
   parameter int unsigned N_W           = DMD_N_W,
   parameter int unsigned A_W           = DMD_A_W,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          COUNT_FALLING = 1'b0,
   parameter int unsigned DEF_N         = 10,
   parameter int unsigned DEF_A         = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fin,
   input  logic [N_W-1:0] prog_n,
   input  logic [A_W-1:0] prog_a,
   input  logic           prog_load,
   output logic           mod_ctrl,
   output logic           fv
);

   if (N_W < 1 || N_W > 16) begin : g_bad_nw
      $error("dmd_feedback_divider: N_W out of range");
   end
   if (A_W < 1 || A_W > 16) begin : g_bad_aw
      $error("dmd_feedback_divider: A_W out of range");
   end
   if (DEF_N < 1 || DEF_N > dmd_max_val(N_W)) begin : g_bad_defn
      $error("dmd_feedback_divider: DEF_N must be 1..2**N_W-1");
   end
   if (DEF_A > dmd_max_val(A_W)) begin : g_bad_defa
      $error("dmd_feedback_divider: DEF_A does not fit A_W");
   end

   logic           ev;
   logic [N_W-1:0] pend_n;
   logic [A_W-1:0] pend_a;

   dmd_fin_edge #(
      .SYNC_STAGES   (SYNC_STAGES),
      .COUNT_FALLING (COUNT_FALLING)
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .fin   (fin),
      .hit   (ev)
   );

   dmd_ratio_shadow #(
      .N_W   (N_W),
      .A_W   (A_W),
      .DEF_N (DEF_N),
      .DEF_A (DEF_A)
   ) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_load (prog_load),
      .prog_n    (prog_n),
      .prog_a    (prog_a),
      .pend_n    (pend_n),
      .pend_a    (pend_a)
   );

   dmd_count_core #(
      .N_W   (N_W),
      .A_W   (A_W),
      .DEF_N (DEF_N),
      .DEF_A (DEF_A)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .pend_n   (pend_n),
      .pend_a   (pend_a),
      .mod_ctrl (mod_ctrl),
      .fv       (fv)
   );

endmodule

// File: tb/dmd_feedback_divider_bench.sv
module dmd_feedback_divider_bench;

   localparam int P = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fin = 1'b0;
   logic [9:0] prog_n = '0;
   logic [6:0] prog_a = '0;
   logic       prog_load = 1'b0;
   logic       mod_ctrl;
   logic       fv;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   dmd_feedback_divider u_dmd_feedback_divider (
      .clk       (clk),
      .rst_n     (rst_n),
      .fin       (fin),
      .prog_n    (prog_n),
      .prog_a    (prog_a),
      .prog_load (prog_load),
      .mod_ctrl  (mod_ctrl),
      .fv        (fv)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One prescaler output period: costs P or P+1 input periods by mod_ctrl.
   task automatic fin_edge(inout int ticks, inout int lows,
                           output bit saw_fv, output int fvw);
      ticks += mod_ctrl ? P : P + 1;
      if (!mod_ctrl) lows++;
      fvw = 0;
      fin = 1'b1;
      repeat (3) begin
         @(negedge clk);
         if (fv) fvw++;
      end
      fin = 1'b0;
      repeat (3) begin
         @(negedge clk);
         if (fv) fvw++;
      end
      saw_fv = (fvw > 0);
   endtask

   task automatic align();
      int t = 0, l = 0, w;
      bit s = 1'b0;
      for (int k = 0; k < 1100 && !s; k++) fin_edge(t, l, s, w);
   endtask

   task automatic measure(output int ticks, output int lows,
                          output int edges, output int maxw);
      bit s = 1'b0;
      int w;
      ticks = 0; lows = 0; edges = 0; maxw = 0;
      while (!s && edges < 1100) begin
         fin_edge(ticks, lows, s, w);
         edges++;
         if (w > maxw) maxw = w;
      end
   endtask

   task automatic write_ratio(input int n, input int a);
      prog_n = 10'(n);
      prog_a = 7'(a);
      prog_load = 1'b1;
      @(negedge clk);
      prog_load = 1'b0;
   endtask

   task automatic t_reset();
      int t, l, e, w;
      check(fv == 1'b0, "R1 fv after reset", fv, 0);
      check(mod_ctrl == 1'b1, "R1 mod_ctrl after reset", mod_ctrl, 1);
      align();
      measure(t, l, e, w);
      check(t == 10 * P, "R1 default ratio", t, 10 * P);
      check(e == 10, "R1 default edge count", e, 10);
   endtask

   task automatic t_basic();
      int t, l, e, w;
      write_ratio(10, 3);
      align();
      measure(t, l, e, w);
      check(t == 10 * P + 3, "R5 ratio N=10 A=3", t, 10 * P + 3);
      check(l == 3, "R3 low edges A=3", l, 3);
      check(e - l == 7, "R4 high edges N-A", e - l, 7);
      check(w == 1, "R6 fv width", w, 1);
   endtask

   task automatic t_a_zero();
      int t, l, e, w;
      write_ratio(7, 0);
      align();
      measure(t, l, e, w);
      check(t == 7 * P, "R4 ratio A=0", t, 7 * P);
      check(l == 0, "R4 mod_ctrl high all cycle", l, 0);
   endtask

   task automatic t_n_one();
      int t, l, e, w;
      write_ratio(1, 0);
      align();
      for (int k = 0; k < 3; k++) begin
         measure(t, l, e, w);
         check(e == 1, "R7 fv every edge", e, 1);
         check(w == 1, "R6 fv width N=1", w, 1);
      end
   endtask

   task automatic t_latency();
      int hits;
      // N=1 active from the previous task: each edge produces fv.
      fin = 1'b1;
      hits = 0;
      @(negedge clk); if (fv) hits++;
      @(negedge clk); if (fv) hits++;
      check(hits == 0, "R2 fv not early", hits, 0);
      @(negedge clk);
      check(fv == 1'b1, "R2 fv on third edge", fv, 1);
      // fin stays high: no further counts.
      hits = 0;
      repeat (20) begin
         @(negedge clk);
         if (fv) hits++;
      end
      check(hits == 0, "R2 held fin counts once", hits, 0);
      fin = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_deferred();
      int t, l, e, w;
      write_ratio(5, 2);
      align();
      write_ratio(12, 4);
      measure(t, l, e, w);
      check(t == 5 * P + 2, "R8 current cycle keeps old ratio", t, 5 * P + 2);
      measure(t, l, e, w);
      check(t == 12 * P + 4, "R8 next cycle uses new ratio", t, 12 * P + 4);
   endtask

   task automatic t_zero_ignored();
      int t, l, e, w;
      write_ratio(0, 9);
      align();
      measure(t, l, e, w);
      check(t == 12 * P + 4, "R9 zero-N write discarded", t, 12 * P + 4);
      check(l == 4, "R9 swallow kept", l, 4);
   endtask

   task automatic t_a_over_n();
      int t, l, e, w;
      write_ratio(2, 5);
      align();
      measure(t, l, e, w);
      check(e == 2, "R10 cycle ends after N", e, 2);
      check(t == 2 * (P + 1), "R10 ratio N*(P+1)", t, 2 * (P + 1));
      check(l == 2, "R10 mod_ctrl low throughout", l, 2);
   endtask

   task automatic t_extreme();
      int t, l, e, w;
      write_ratio(1023, 127);
      align();
      measure(t, l, e, w);
      check(t == 1023 * P + 127, "R11 max ratio", t, 1023 * P + 127);
      check(l == 127, "R11 max swallow", l, 127);
   endtask

   initial begin
      #(1_900_000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_a_zero();
      t_n_one();
      t_latency();
      t_deferred();
      t_zero_ignored();
      t_a_over_n();
      t_extreme();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule